// File: doc/BRIEF.md
# LED and Stop Output Controller

This block drives the indicator and stop-signal pins of a voice playback controller. It takes the stop-level register, the mode register, a flag that is high while a voice is playing, and the LED-enable bit of the section now playing. From these it produces two LED drives, two dedicated stop outputs, and one shared pin that can carry a second LED drive, a third stop level, or nothing at all because it is being used as a trigger input.

While playing, the LEDs either stay lit or flash as a 50 % duty square wave. The flash rate comes from a divider sized from the clock frequency and the target rate, 3 Hz by default. The flash always restarts in its lit phase when playback begins. A flash-type input picks whether the second LED flashes in step with the first or in the opposite phase. When the section LED bit is clear, or nothing is playing, both LEDs are dark.

Every output is registered once, so each pin settles one clock edge after the inputs that decide it.

Top module: `led_stop_ctrl`

## Requirements
- R1: `stpa_o` equals bit 0 and `stpb_o` equals bit 1 of `stop_reg_i`, one clock edge after the register value is presented. A 1 drives the output high and a 0 drives it low. Bits 7 to 3 of `stop_reg_i` have no effect on any output.
- R2: When bit 5 and bit 6 of `mode_reg_i` are both 0, the shared pin is a third stop output. `pin4_oe_o` is 1 and `pin4_o` equals bit 2 of `stop_reg_i`, whether or not playback is active.
- R3: While playing with flashing selected, the first LED is lit for the first HALF edges of playback and dark for the next HALF edges, and keeps alternating in that pattern. HALF = CLK_FREQ_HZ / (2 * FLASH_HZ). The pattern restarts in the lit phase each time `playing_i` rises.
- R4: When bit 5 of `mode_reg_i` is 1, the shared pin is a trigger input. `pin4_oe_o` is 0 and `pin4_o` is 0.
- R5: When `playing_i` is 0, both LED drives are 0.
- R6: When `sect_led_i` is 0, both LED drives are 0.
- R7: When bit 7 of `mode_reg_i` is 0, the LEDs are steady: each LED drive is 1 whenever `playing_i` and `sect_led_i` are both 1.
- R8: When bit 5 of `mode_reg_i` is 0 and bit 6 is 1, the shared pin carries the second LED drive with `pin4_oe_o` at 1. In flashing mode, `alt_flash_i` = 0 puts it in the same phase as the first LED and `alt_flash_i` = 1 puts it in the opposite phase.
- R9: While `rst_ni` is low, every output, including `pin4_oe_o`, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_reg_i | input | 8 | Stop-level register; bits 0..2 give stop A, B and C |
| mode_reg_i | input | 8 | Mode register; bit 7 flash, bit 6 LED2/stop C, bit 5 trigger input |
| playing_i | input | 1 | High while a voice is playing |
| sect_led_i | input | 1 | LED-enable bit of the current play section |
| alt_flash_i | input | 1 | 0 selects in-phase flashing, 1 selects opposite-phase flashing |
| led1_o | output | 1 | First LED drive |
| pin4_o | output | 1 | Shared pin output value |
| pin4_oe_o | output | 1 | Shared pin output enable |
| stpa_o | output | 1 | Stop output A |
| stpb_o | output | 1 | Stop output B |

## Verification
Every output of this block is due exactly one clock edge after the inputs that decide it. Register-to-pin paths (stop levels, pin role, output enable) follow the values present at that edge. The LED drives follow the flash phase as it stood before that edge, so the first edge of playback always shows the lit phase. The bench drives inputs just after a falling edge and compares every output at the next falling edge. Its expected values come from a model updated on the rising edge, which counts the edges spent playing. This keeps the comparison half a cycle away from the edge at which the design and model update.

// File: rtl/led_stop_pkg.sv
package led_stop_pkg;

  localparam int MODE_FLASH_BIT = 7;
  localparam int MODE_LED2_BIT  = 6;
  localparam int MODE_TRIG_BIT  = 5;

  localparam int STOP_A_BIT = 0;
  localparam int STOP_B_BIT = 1;
  localparam int STOP_C_BIT = 2;

  typedef enum logic [1:0] {
    P4_INPUT = 2'd0,
    P4_LED2  = 2'd1,
    P4_STOPC = 2'd2
  } pin4_role_e;

  function automatic pin4_role_e decode_role(input logic [7:0] mode);
    if (mode[MODE_TRIG_BIT])     return P4_INPUT;
    else if (mode[MODE_LED2_BIT]) return P4_LED2;
    else                          return P4_STOPC;
  endfunction

endpackage

// File: rtl/flash_timebase.sv
module flash_timebase #(
  parameter int HALF_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_o
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  // idle holds the divider in the lit phase so playback starts lit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  a_r3_idle_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> phase_q);

  a_r3_hold_mid_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q != LAST) |=> $stable(phase_q));

  a_r3_toggle_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_q == LAST) |=> phase_q != $past(phase_q));

endmodule

// File: rtl/led_gate.sv
module led_gate #(
  parameter int NUM_LEDS = 2
) (
  input  logic                playing_i,
  input  logic                sect_led_i,
  input  logic                flash_en_i,
  input  logic                alt_i,
  input  logic                phase_i,
  output logic [NUM_LEDS-1:0] led_o
);
  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    localparam bit ODD = (i % 2) == 1;
    logic lit;
    // odd-numbered LEDs take the opposite phase in alternate mode
    assign lit      = flash_en_i ? (phase_i ^ (alt_i & ODD)) : 1'b1;
    assign led_o[i] = playing_i & sect_led_i & lit;
  end
endmodule

// File: rtl/pin4_mux.sv
module pin4_mux
  import led_stop_pkg::*;
(
  input  pin4_role_e role_i,
  input  logic       led2_i,
  input  logic       stopc_i,
  output logic       pin_o,
  output logic       oe_o
);
  always_comb begin
    unique case (role_i)
      P4_LED2:  begin pin_o = led2_i;  oe_o = 1'b1; end
      P4_STOPC: begin pin_o = stopc_i; oe_o = 1'b1; end
      default:  begin pin_o = 1'b0;    oe_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/led_stop_ctrl.sv
module led_stop_ctrl
  import led_stop_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 3000000,
  parameter int FLASH_HZ    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] stop_reg_i,
  input  logic [7:0] mode_reg_i,
  input  logic       playing_i,
  input  logic       sect_led_i,
  input  logic       alt_flash_i,
  output logic       led1_o,
  output logic       pin4_o,
  output logic       pin4_oe_o,
  output logic       stpa_o,
  output logic       stpb_o
);
  localparam int HALF_CYCLES = CLK_FREQ_HZ / (2 * FLASH_HZ);
  localparam int NUM_LEDS    = 2;
  localparam int OUT_W       = 5;

  logic                phase;
  logic [NUM_LEDS-1:0] led;
  pin4_role_e          role;
  logic                p4_val, p4_oe;
  logic [OUT_W-1:0]    out_d, out_q;
  logic                unused_bits;

  assign unused_bits = ^{stop_reg_i[7:3], mode_reg_i[4:0]};

  flash_timebase #(.HALF_CYCLES(HALF_CYCLES)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (playing_i),
    .phase_o (phase)
  );

  led_gate #(.NUM_LEDS(NUM_LEDS)) u_gate (
    .playing_i  (playing_i),
    .sect_led_i (sect_led_i),
    .flash_en_i (mode_reg_i[MODE_FLASH_BIT]),
    .alt_i      (alt_flash_i),
    .phase_i    (phase),
    .led_o      (led)
  );

  assign role = decode_role(mode_reg_i);

  pin4_mux u_mux (
    .role_i  (role),
    .led2_i  (led[1]),
    .stopc_i (stop_reg_i[STOP_C_BIT]),
    .pin_o   (p4_val),
    .oe_o    (p4_oe)
  );

  assign out_d = {led[0], p4_val, p4_oe,
                  stop_reg_i[STOP_B_BIT], stop_reg_i[STOP_A_BIT]};

  out_stage #(.WIDTH(OUT_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (out_d),
    .q_o    (out_q)
  );

  assign {led1_o, pin4_o, pin4_oe_o, stpb_o, stpa_o} = out_q;

  a_r1_stop_ab_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stpa_o == $past(stop_reg_i[0])) && (stpb_o == $past(stop_reg_i[1])));

  a_r2_stopc_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_reg_i[5] && !mode_reg_i[6]) |=> pin4_oe_o && (pin4_o == $past(stop_reg_i[2])));

  a_r4_input_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_reg_i[5] |=> !pin4_oe_o && !pin4_o);

  a_r5_idle_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !playing_i |=> !led1_o);

  a_r6_section_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sect_led_i |=> !led1_o);

  a_r7_steady_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (playing_i && sect_led_i && !mode_reg_i[7]) |=> led1_o);

  a_r8_alt_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (playing_i && sect_led_i && mode_reg_i[7] && !mode_reg_i[5] && mode_reg_i[6]
     && alt_flash_i) |=> (pin4_o != led1_o));

  a_r8_sync_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_reg_i[5] && mode_reg_i[6] && !alt_flash_i) |=> (pin4_o == led1_o));

  always_comb begin
    if (!rst_ni) begin
      a_r9_reset_low: assert (out_q == '0);
    end
  end

endmodule

// File: tb/tb_led_stop_ctrl.sv
module tb_led_stop_ctrl;
  localparam int CLK_HZ = 600;
  localparam int FL_HZ  = 3;
  localparam int HALF   = CLK_HZ / (2 * FL_HZ);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stop_reg = 8'h00;
  logic [7:0] mode_reg = 8'hF0;
  logic       playing = 1'b0;
  logic       sect = 1'b0;
  logic       alt = 1'b0;
  logic       led1, p4, p4_oe, stpa, stpb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  led_stop_ctrl #(.CLK_FREQ_HZ(CLK_HZ), .FLASH_HZ(FL_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_reg_i(stop_reg), .mode_reg_i(mode_reg),
    .playing_i(playing), .sect_led_i(sect), .alt_flash_i(alt),
    .led1_o(led1), .pin4_o(p4), .pin4_oe_o(p4_oe), .stpa_o(stpa), .stpb_o(stpb)
  );

  always #5 clk = ~clk;

  // reference model, from the requirements
  int    play_edges;
  logic  e_led1, e_p4, e_oe, e_a, e_b;
  string led_tag, p4_tag;

  function automatic logic led_expect(input logic ply, input logic sc, input logic flash,
                                      input logic ph);
    if (!ply || !sc) return 1'b0;
    if (!flash)      return 1'b1;
    return ph;
  endfunction

  function automatic string led_reason(input logic ply, input logic sc, input logic flash);
    if (!ply)   return "R5";
    if (!sc)    return "R6";
    if (!flash) return "R7";
    return "R3";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_edges = 0;
      {e_led1, e_p4, e_oe, e_a, e_b} = '0;
      led_tag = "R9"; p4_tag = "R9";
    end else begin
      logic ph;
      ph = ((play_edges / HALF) % 2) == 0;
      e_a = stop_reg[0];
      e_b = stop_reg[1];
      e_led1 = led_expect(playing, sect, mode_reg[7], ph);
      led_tag = led_reason(playing, sect, mode_reg[7]);
      if (mode_reg[5]) begin
        e_oe = 1'b0; e_p4 = 1'b0; p4_tag = "R4";
      end else if (mode_reg[6]) begin
        e_oe = 1'b1; e_p4 = led_expect(playing, sect, mode_reg[7], ph ^ alt); p4_tag = "R8";
      end else begin
        e_oe = 1'b1; e_p4 = stop_reg[2]; p4_tag = "R2";
      end
      if (playing) play_edges++;
      else         play_edges = 0;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1", "stpa", stpa, e_a);
    chk("R1", "stpb", stpb, e_b);
    chk(led_tag, "led1", led1, e_led1);
    chk(p4_tag, "pin4_oe", p4_oe, e_oe);
    chk(p4_tag, "pin4", p4, e_p4);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: done=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    stop_reg = 8'h07; mode_reg = 8'h80; playing = 1'b1; sect = 1'b1;
    // R9: outputs held low in reset despite active inputs
    run(4);
    chk("R9", "reset led1", led1, 1'b0);
    chk("R9", "reset oe", p4_oe, 1'b0);
    rst_n = 1'b1;
    playing = 1'b0;
    run(3);

    // R1: upper stop bits ignored, low bits follow
    stop_reg = 8'hF8; run(2);
    chk("R1", "stpa with bits7..3 set", stpa, 1'b0);
    stop_reg = 8'h03; run(2);
    chk("R1", "stpb", stpb, 1'b1);

    // R2: third stop output on pin 4
    mode_reg = 8'h80; stop_reg = 8'h04; run(2);
    chk("R2", "stopc high", p4, 1'b1);
    stop_reg = 8'hFB; run(2);
    chk("R2", "stopc low", p4, 1'b0);

    // R3/R8: synchronous flash, full period, LED2 in phase
    mode_reg = 8'hC0; alt = 1'b0; sect = 1'b1; playing = 1'b1;
    @(negedge clk); check_all();
    chk("R3", "first play edge lit", led1, 1'b1);
    run(HALF);
    chk("R3", "second half dark", led1, 1'b0);
    chk("R8", "sync led2 dark", p4, 1'b0);
    run(HALF);
    chk("R3", "third half lit", led1, 1'b1);

    // R8: alternate phase, restart lit on new playback
    playing = 1'b0; run(3);
    alt = 1'b1; playing = 1'b1; run(1);
    chk("R3", "restart lit", led1, 1'b1);
    chk("R8", "alt led2 dark", p4, 1'b0);
    run(HALF);
    chk("R8", "alt led2 lit", p4, 1'b1);

    // R6 and R7
    sect = 1'b0; run(3);
    chk("R6", "section off", led1, 1'b0);
    sect = 1'b1; mode_reg = 8'h40; run(2 * HALF);
    chk("R7", "steady lit", led1, 1'b1);

    // R4: pin 4 as trigger input
    mode_reg = 8'hE4; stop_reg = 8'h04; run(3);
    chk("R4", "input oe", p4_oe, 1'b0);
    chk("R4", "input pin", p4, 1'b0);

    // R5
    playing = 1'b0; mode_reg = 8'hC0; run(2);
    chk("R5", "idle dark", led1, 1'b0);

    // random section
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 99);
      stop_reg = 8'($urandom);
      if (r < 20) mode_reg = 8'($urandom);
      if (r < 10) playing = ~playing;
      if (r > 90) sect = ~sect;
      if (r == 50) alt = ~alt;
      run($urandom_range(1, 40));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule